// File: doc/BRIEF.md
# Repeated-Address Access Filter

This block sits between a vector address sequencer and a single memory port. It handles commands in which every element of a vector access targets one and the same address. This happens when a scalar base is combined with a zero offset step. Each command carries a cache-inhibited attribute, a direction (load or store), a vector length and an element predicate mask. The filter decides whether the repeated accesses may be merged or must be replayed one by one.

Cacheable accesses are merged:
- A cacheable load performs a single memory read. It then copies that value into every predicate-active destination element, one register write per cycle.
- A cacheable store keeps only the write of the highest-numbered active element, because every earlier write to the same address would be overwritten.

Cache-inhibited accesses may target a peripheral, so the filter replays them. Every active element gets its own memory access, in ascending element order.

Only elements whose predicate bit is set and whose index is below the vector length take part. A command with no such element completes without touching memory. The store data of the element being issued is fetched through a register read index. Load results leave through a destination write port.

Top module: `splat_filter`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1 and `mem_req`, `dst_we` and `done` are 0.
- R2: Element i is active when `cmd_mask[i]` is 1 and i < `cmd_vl`. A `cmd_vl` above `VL_MAX` is treated as `VL_MAX`.
- R3: A command with no active element issues no memory access and no destination write. `done` is 1 in the cycle after the command is accepted.
- R4: A cacheable load (`cmd_ci`=0, `cmd_store`=0) issues exactly one read (`mem_we`=0) with `src_idx` equal to the lowest active element. It then writes the returned data to every active element in ascending order, one element per cycle on consecutive cycles.
- R5: A cache-inhibited load issues one read per active element in ascending order. Each returned value is written to that element's destination index before the next read is issued.
- R6: A cacheable store (`cmd_ci`=0, `cmd_store`=1) issues exactly one write (`mem_we`=1). `src_idx` equals the highest active element and `mem_wdata` equals `src_data`.
- R7: A cache-inhibited store issues one write per active element in ascending element order, each carrying `src_data` for that element.
- R8: While `mem_req` is 1 and `mem_gnt` is 0, the next cycle keeps `mem_req` at 1 and `src_idx` unchanged.
- R9: `done` is a single-cycle pulse ending each command. `cmd_ready` is 0 from acceptance until after `done`, and `cmd_valid` is ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; taken when `cmd_ready` is 1 |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_ci | input | 1 | 1 = cache-inhibited (replay every access) |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_vl | input | VLW | Vector length |
| cmd_mask | input | VL_MAX | Predicate, bit i belongs to element i |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_wdata | output | DW | Store data |
| mem_rvalid | input | 1 | Read data valid (at least one cycle after grant) |
| mem_rdata | input | DW | Read data |
| src_idx | output | IW | Element index of the access being issued; selects store source |
| src_data | input | DW | Source register value for `src_idx` |
| dst_we | output | 1 | Destination register write enable |
| dst_idx | output | IW | Destination element index |
| dst_data | output | DW | Destination write data |
| done | output | 1 | Command complete pulse |

## Verification
The bench aims at the element-selection corners. Sparse masks whose lowest and highest active elements differ catch a cacheable store that writes the first element instead of the last, or a merged load that reads at the wrong element. A vector length above the element count, a zero length and a mask with no bit below the length catch a filter that lets masked elements through or hangs waiting for an access that never comes. Replayed loads are checked for a fresh read before each destination write, which a design that merged them would skip. Requests are held for a cycle before grant, and a command is offered while busy, to catch an index that moves before grant or a second command that is taken early.

// File: rtl/splat_pkg.sv
package splat_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ISSUE = 3'd1,
    S_WAIT  = 3'd2,
    S_WRITE = 3'd3,
    S_DONE  = 3'd4
  } fsm_e;
endpackage

// File: rtl/splat_plan.sv
module splat_plan #(
  parameter int N   = 8,
  parameter int VLW = 4
) (
  input  logic           ci,
  input  logic           store,
  input  logic [VLW-1:0] vl,
  input  logic [N-1:0]   mask,
  output logic [N-1:0]   act,
  output logic           from_top
);
  function automatic logic [N-1:0] live_set(input logic [N-1:0] m, input logic [VLW-1:0] len);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = m[i] && (i < int'(len));
    return r;
  endfunction

  assign act      = live_set(mask, vl);
  assign from_top = store && !ci;
endmodule

// File: rtl/splat_pick.sv
module splat_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] cur,
  output logic          any,
  output logic [IW-1:0] first_idx,
  output logic [IW-1:0] last_idx,
  output logic          nxt_found,
  output logic [IW-1:0] nxt_idx
);
  always_comb begin
    first_idx = '0;
    last_idx  = '0;
    nxt_found = 1'b0;
    nxt_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) first_idx = IW'(i);
      if (mask[i] && (i > int'(cur))) begin
        nxt_found = 1'b1;
        nxt_idx   = IW'(i);
      end
    end
    for (int i = 0; i < N; i++) begin
      if (mask[i]) last_idx = IW'(i);
    end
  end
  assign any = |mask;
endmodule

// File: rtl/splat_filter.sv
module splat_filter #(
  parameter int VL_MAX = 8,
  parameter int DW     = 16,
  localparam int IW    = $clog2(VL_MAX),
  localparam int VLW   = $clog2(VL_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_ci,
  input  logic           cmd_store,
  input  logic [VLW-1:0] cmd_vl,
  input  logic [VL_MAX-1:0] cmd_mask,
  output logic           mem_req,
  output logic           mem_we,
  input  logic           mem_gnt,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic [IW-1:0]  src_idx,
  input  logic [DW-1:0]  src_data,
  output logic           dst_we,
  output logic [IW-1:0]  dst_idx,
  output logic [DW-1:0]  dst_data,
  output logic           done
);
  import splat_pkg::*;

  fsm_e st_q, st_n;
  logic [VL_MAX-1:0] act_q, act_n;
  logic [IW-1:0]     cur_q, cur_n;
  logic              ci_q, ci_n, sto_q, sto_n;
  logic [DW-1:0]     data_q, data_n;

  logic [VL_MAX-1:0] plan_act;
  logic              plan_top;
  logic [VL_MAX-1:0] pk_mask;
  logic              pk_any, pk_nxt_found;
  logic [IW-1:0]     pk_first, pk_last, pk_nxt;

  // named events for the checks
  logic accept_ev, issue_fire, zero_cmd_ev;

  splat_plan #(.N(VL_MAX), .VLW(VLW)) u_plan (
    .ci(cmd_ci), .store(cmd_store), .vl(cmd_vl), .mask(cmd_mask),
    .act(plan_act), .from_top(plan_top)
  );

  assign pk_mask = (st_q == S_IDLE) ? plan_act : act_q;

  splat_pick #(.N(VL_MAX), .IW(IW)) u_pick (
    .mask(pk_mask), .cur(cur_q), .any(pk_any),
    .first_idx(pk_first), .last_idx(pk_last),
    .nxt_found(pk_nxt_found), .nxt_idx(pk_nxt)
  );

  assign accept_ev   = (st_q == S_IDLE) && cmd_valid;
  assign zero_cmd_ev = accept_ev && !pk_any;
  assign issue_fire  = mem_req && mem_gnt;

  always_comb begin
    st_n = st_q; cur_n = cur_q; act_n = act_q;
    ci_n = ci_q; sto_n = sto_q; data_n = data_q;
    case (st_q)
      S_IDLE: if (cmd_valid) begin
        act_n = plan_act;
        ci_n  = cmd_ci;
        sto_n = cmd_store;
        if (!pk_any) st_n = S_DONE;
        else begin
          cur_n = plan_top ? pk_last : pk_first;
          st_n  = S_ISSUE;
        end
      end
      S_ISSUE: if (mem_gnt) begin
        if (sto_q) begin
          if (ci_q && pk_nxt_found) cur_n = pk_nxt;
          else st_n = S_DONE;
        end else st_n = S_WAIT;
      end
      S_WAIT: if (mem_rvalid) begin
        data_n = mem_rdata;
        st_n   = S_WRITE;
      end
      S_WRITE: if (pk_nxt_found) begin
        cur_n = pk_nxt;
        st_n  = ci_q ? S_ISSUE : S_WRITE;
      end else st_n = S_DONE;
      S_DONE:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cur_q <= '0; act_q <= '0;
      ci_q <= 1'b0; sto_q <= 1'b0; data_q <= '0;
    end else begin
      st_q <= st_n; cur_q <= cur_n; act_q <= act_n;
      ci_q <= ci_n; sto_q <= sto_n; data_q <= data_n;
    end
  end

  assign cmd_ready = (st_q == S_IDLE);
  assign mem_req   = (st_q == S_ISSUE);
  assign mem_we    = mem_req && sto_q;
  assign mem_wdata = src_data;
  assign src_idx   = cur_q;
  assign dst_we    = (st_q == S_WRITE);
  assign dst_idx   = cur_q;
  assign dst_data  = data_q;
  assign done      = (st_q == S_DONE);

  // R3
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cmd_ev |=> done && !mem_req);
  // R6
  merged_store_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && sto_q && !ci_q) |-> (src_idx == pk_last));
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(src_idx)));
  // R4
  dst_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && $past(dst_we)) |-> (dst_idx > $past(dst_idx)));
  // R2
  dst_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> act_q[dst_idx]);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);
endmodule

// File: tb/splat_filter_bench.sv
module splat_filter_bench;
  localparam int N = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ci = 1'b0, cmd_store = 1'b0;
  logic [3:0] cmd_vl = '0;
  logic [N-1:0] cmd_mask = '0;
  logic cmd_ready, mem_req, mem_we, dst_we, done;
  logic mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] mem_wdata, src_data, dst_data;
  logic [2:0] src_idx, dst_idx;

  always #5 clk = ~clk;

  assign src_data = 16'h5000 + {13'd0, src_idx};

  splat_filter #(.VL_MAX(N), .DW(DW)) u_splat_filter (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_ci(cmd_ci), .cmd_store(cmd_store), .cmd_vl(cmd_vl), .cmd_mask(cmd_mask),
    .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .src_idx(src_idx),
    .src_data(src_data), .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
    .done(done)
  );

  int n_chk = 0, n_fail = 0;
  int n_acc = 0, n_dw = 0, n_done = 0, rd_seq = 0, rv_cnt = 0, hold_err = 0;
  int acc_idx[64], acc_we[64], acc_wd[64], dw_idx[64], dw_data[64];
  logic hold = 1'b0, prev_req = 1'b0;
  logic [2:0] prev_idx = '0;

  // {ci, store, vl[3:0], mask[7:0]}
  localparam logic [13:0] TBL [10] = '{
    {1'b0, 1'b0, 4'd8,  8'hFF},
    {1'b0, 1'b0, 4'd5,  8'hB6},
    {1'b1, 1'b0, 4'd8,  8'h29},
    {1'b0, 1'b1, 4'd8,  8'h29},
    {1'b1, 1'b1, 4'd6,  8'hFF},
    {1'b0, 1'b1, 4'd8,  8'h01},
    {1'b1, 1'b0, 4'd15, 8'h81},
    {1'b0, 1'b0, 4'd0,  8'hFF},
    {1'b1, 1'b1, 4'd3,  8'hF8},
    {1'b0, 1'b1, 4'd15, 8'hC0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 1'b0; hold = 1'b0; rv_cnt = 0; mem_rvalid = 1'b0;
      prev_req = 1'b0;
    end else begin
      mem_rvalid = 1'b0;
      if (rv_cnt > 0) begin
        rv_cnt--;
        if (rv_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = 16'hA000 + 16'(rd_seq);
          rd_seq++;
        end
      end
      if (mem_req && prev_req && !mem_gnt && src_idx != prev_idx) hold_err++;
      prev_req = mem_req;
      prev_idx = src_idx;
      if (mem_req && !mem_gnt) begin
        if (hold) begin
          mem_gnt = 1'b1; hold = 1'b0;
          acc_idx[n_acc] = int'(src_idx);
          acc_we[n_acc]  = int'(mem_we);
          acc_wd[n_acc]  = int'(mem_wdata);
          n_acc++;
          if (!mem_we) rv_cnt = 2;
        end else hold = 1'b1;
      end else mem_gnt = 1'b0;
      if (dst_we) begin
        dw_idx[n_dw] = int'(dst_idx);
        dw_data[n_dw] = int'(dst_data);
        n_dw++;
      end
      if (done) n_done++;
    end
  end

  task automatic clear_log();
    n_acc = 0; n_dw = 0; n_done = 0;
  endtask

  task automatic issue(input logic ci, input logic st, input logic [3:0] vl, input logic [7:0] m);
    @(negedge clk); #1;
    cmd_ci = ci; cmd_store = st; cmd_vl = vl; cmd_mask = m; cmd_valid = 1'b1;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 200 && n_done == 0; k++) begin
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
  endtask

  task automatic run_entry(input logic [13:0] e);
    logic ci, st;
    logic [3:0] vl;
    logic [7:0] m, act;
    int nact, base, k, exp_acc;
    int list[8];
    string tg;
    ci = e[13]; st = e[12]; vl = e[11:8]; m = e[7:0];
    nact = 0;
    for (int i = 0; i < N; i++) begin
      act[i] = m[i] && (i < int'(vl));
      if (act[i]) begin list[nact] = i; nact++; end
    end
    tg = (nact == 0) ? "R3" : ci ? (st ? "R7" : "R5") : (st ? "R6" : "R4");
    clear_log();
    base = rd_seq;
    issue(ci, st, vl, m);
    wait_done();
    exp_acc = (nact == 0) ? 0 : (ci ? nact : 1);
    chk(n_acc == exp_acc, tg, n_acc, exp_acc);
    if (vl > 4'd8) chk(n_acc == exp_acc, "R2", n_acc, exp_acc);
    chk(n_done == 1, "R9", n_done, 1);
    if (n_acc == exp_acc) begin
      for (int a = 0; a < exp_acc; a++) begin
        k = (ci || !st) ? list[a] : list[nact-1];
        chk(acc_idx[a] == k, tg, acc_idx[a], k);
        chk(acc_we[a] == int'(st), tg, acc_we[a], int'(st));
        if (st) chk(acc_wd[a] == 16'h5000 + k, tg, acc_wd[a], 16'h5000 + k);
      end
    end
    if (!st) begin
      chk(n_dw == nact, tg, n_dw, nact);
      if (n_dw == nact)
        for (int a = 0; a < nact; a++) begin
          chk(dw_idx[a] == list[a], tg, dw_idx[a], list[a]);
          k = 16'hA000 + base + (ci ? a : 0);
          chk(dw_data[a] == k, tg, dw_data[a], k);
        end
    end else chk(n_dw == 0, tg, n_dw, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1", int'(cmd_ready), 1);
    chk(mem_req == 1'b0, "R1", int'(mem_req), 0);
    chk(dst_we == 1'b0, "R1", int'(dst_we), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;

    foreach (TBL[i]) run_entry(TBL[i]);

    // R3 done exactly one cycle after acceptance
    clear_log();
    @(negedge clk); #1;
    cmd_ci = 1'b1; cmd_store = 1'b0; cmd_vl = 4'd2; cmd_mask = 8'hFC; cmd_valid = 1'b1;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
    chk(done == 1'b1, "R3", int'(done), 1);
    chk(cmd_ready == 1'b0, "R9", int'(cmd_ready), 0);
    @(negedge clk); #1;
    chk(done == 1'b0, "R9", int'(done), 0);
    chk(n_acc == 0, "R3", n_acc, 0);

    // R9 command offered while busy is ignored
    clear_log();
    issue(1'b1, 1'b1, 4'd8, 8'h03);
    chk(cmd_ready == 1'b0, "R9", int'(cmd_ready), 0);
    cmd_ci = 1'b0; cmd_store = 1'b0; cmd_mask = 8'hFF; cmd_valid = 1'b1;
    repeat (3) begin @(negedge clk); #1; end
    cmd_valid = 1'b0;
    wait_done();
    chk(n_acc == 2, "R9", n_acc, 2);
    chk(acc_we[0] == 1 && acc_we[1] == 1, "R9", acc_we[1], 1);
    chk(n_dw == 0, "R9", n_dw, 0);
    chk(n_done == 1, "R9", n_done, 1);

    // R8 request held stable until grant
    chk(hold_err == 0, "R8", hold_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule